// File: doc/BRIEF.md
# Configurable Sample Clock Generator

This block decides when a logic-analyzer front end takes a sample from a source-synchronous bus. The clock and strobe lines of the bus are oversampled in the master clock domain. Four edge detectors watch them, and each detector can be set to see rising edges, falling edges or both. Detectors are bound into clock groups. A group completes an event once every detector selected for it has reported an edge since the group last fired, even when those edges arrive in different cycles.

Group events feed a small set of terms. Each term ANDs a chosen set of group events with a per-bit qualifier match, where each qualifier bit must be high, must be low, or is ignored. The sample enable is the OR of all terms. Bus data is latched on the rising edge of a selected strobe line. The latched word is resynchronized to the master clock and presented with a one-cycle valid pulse whenever the sample enable is true.

Configuration arrives on static ports. It is copied into the block only while reset is asserted, so a change takes effect at the next reset.

Top module: `sample_clock_gen`

## Requirements
- R1: Four detectors exist. Detector d watches the input line whose index is in `cfg_det_src[d*2 +: 2]`.
- R2: Detector d reports a rising edge of its line when `cfg_det_rise[d]` is 1, and a falling edge when `cfg_det_fall[d]` is 1. The two enables are independent, and an edge whose enable is 0 is not reported.
- R3: Group g uses the detectors whose bits are set in `cfg_grp_mask[g*4 +: 4]`. The group fires in the cycle in which the last of its selected detectors has reported an edge since its previous firing. A group with an empty mask never fires.
- R4: When a group fires, all of its remembered edges are cleared, so the next event needs a fresh edge from every selected detector.
- R5: Term t needs every group set in `cfg_term_grp[t*2 +: 2]` to fire in the same cycle. For each qualifier bit q with `cfg_term_care[t*4+q]`=1, it also needs `qual_in[q]` equal to `cfg_term_val[t*4+q]`. A term with no group selected is never true. A sample is taken when any term is true.
- R6: `data_in` is latched on each rising edge of the line selected by `cfg_strb_sel`. A sample carries the most recently latched word, or the word latched in the same cycle.
- R7: An input edge that completes a sample raises `sample_valid` for exactly one cycle, 3 master clock edges after the edge is first sampled. `sample_data` changes only together with `sample_valid`.
- R8: A synchronous reset clears the remembered edges, `sample_valid` and `sample_data`, and loads all configuration ports. A configuration change without a reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high; loads configuration |
| sig_in | input | NSIG | Asynchronous clock and strobe lines of the bus |
| data_in | input | DW | Bus data, captured on the strobe's rising edge |
| qual_in | input | NQ | Qualifier signals, synchronous to clk |
| cfg_det_src | input | NDET*SELW | Input line select per detector |
| cfg_det_rise | input | NDET | Rising-edge enable per detector |
| cfg_det_fall | input | NDET | Falling-edge enable per detector |
| cfg_strb_sel | input | SELW | Input line used as data strobe |
| cfg_grp_mask | input | NGRP*NDET | Detector membership per group |
| cfg_term_grp | input | NTERM*NGRP | Group selection per term |
| cfg_term_care | input | NTERM*NQ | Qualifier bits examined per term |
| cfg_term_val | input | NTERM*NQ | Required qualifier values per term |
| sample_valid | output | 1 | One-cycle sample pulse |
| sample_data | output | DW | Resynchronized sample word |

## Verification
The bench completes a two-detector group across several cycles and checks that a wrong edge polarity on one member does not count. A design that latched single edges as complete events, or ignored the polarity enables, would sample early. After a group fires, the bench feeds a single edge and expects no sample: a design that kept its remembered edges would fire on stale history. The bench also presents a strobe edge and the completing edge in the same cycle, where a design that lagged one word behind would return the previous data. Finally, it changes configuration without a reset, where a design that read the live ports would act on the new setting too early.

// File: rtl/sample_clock_gen.sv
module sample_clock_gen #(
  parameter int NSIG  = 4,
  parameter int NDET  = 4,
  parameter int NGRP  = 2,
  parameter int NTERM = 2,
  parameter int NQ    = 4,
  parameter int DW    = 8,
  localparam int SELW = (NSIG > 1) ? $clog2(NSIG) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSIG-1:0]       sig_in,
  input  logic [DW-1:0]         data_in,
  input  logic [NQ-1:0]         qual_in,
  input  logic [NDET*SELW-1:0]  cfg_det_src,
  input  logic [NDET-1:0]       cfg_det_rise,
  input  logic [NDET-1:0]       cfg_det_fall,
  input  logic [SELW-1:0]       cfg_strb_sel,
  input  logic [NGRP*NDET-1:0]  cfg_grp_mask,
  input  logic [NTERM*NGRP-1:0] cfg_term_grp,
  input  logic [NTERM*NQ-1:0]   cfg_term_care,
  input  logic [NTERM*NQ-1:0]   cfg_term_val,
  output logic                  sample_valid,
  output logic [DW-1:0]         sample_data
);

  logic [NDET*SELW-1:0]  src_q;
  logic [NDET-1:0]       rise_q, fall_q;
  logic [SELW-1:0]       strb_q;
  logic [NGRP*NDET-1:0]  gmask_q;
  logic [NTERM*NGRP-1:0] tgrp_q;
  logic [NTERM*NQ-1:0]   tcare_q, tval_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= cfg_det_src;
      rise_q  <= cfg_det_rise;
      fall_q  <= cfg_det_fall;
      strb_q  <= cfg_strb_sel;
      gmask_q <= cfg_grp_mask;
      tgrp_q  <= cfg_term_grp;
      tcare_q <= cfg_term_care;
      tval_q  <= cfg_term_val;
    end
  end

  logic [NSIG-1:0] s1, s2, sp;
  logic [DW-1:0]   d1, d2;

  always_ff @(posedge clk) begin
    s1 <= sig_in;
    s2 <= s1;
    sp <= s2;
    d1 <= data_in;
    d2 <= d1;
  end

  wire [NSIG-1:0] sig_rise = s2 & ~sp;
  wire [NSIG-1:0] sig_fall = ~s2 & sp;

  logic [NDET-1:0] det_hit;

  always_comb begin
    for (int d = 0; d < NDET; d++) begin
      logic [SELW-1:0] src;
      src = src_q[d*SELW +: SELW];
      det_hit[d] = (rise_q[d] & sig_rise[src]) | (fall_q[d] & sig_fall[src]);
    end
  end

  logic [NGRP*NDET-1:0] seen, acc;
  logic [NGRP-1:0]      grp_evt;

  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      logic [NDET-1:0] gm;
      gm = gmask_q[g*NDET +: NDET];
      acc[g*NDET +: NDET] = seen[g*NDET +: NDET] | (det_hit & gm);
      grp_evt[g] = (|gm) && (acc[g*NDET +: NDET] == gm);
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NGRP; g++) begin
      if (rst || grp_evt[g]) seen[g*NDET +: NDET] <= '0;
      else                   seen[g*NDET +: NDET] <= acc[g*NDET +: NDET];
    end
  end

  logic fire;

  always_comb begin
    fire = 1'b0;
    for (int t = 0; t < NTERM; t++) begin
      logic [NGRP-1:0] tg;
      tg = tgrp_q[t*NGRP +: NGRP];
      if ((|tg) && ((grp_evt & tg) == tg) &&
          (((qual_in ^ tval_q[t*NQ +: NQ]) & tcare_q[t*NQ +: NQ]) == '0))
        fire = 1'b1;
    end
  end

  logic [DW-1:0] cap;
  wire           strb_rise = sig_rise[strb_q];
  wire [DW-1:0]  cur_word  = strb_rise ? d2 : cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap          <= '0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
    end else begin
      if (strb_rise) cap <= d2;
      sample_valid <= fire;
      if (fire) sample_data <= cur_word;
    end
  end

endmodule

module sample_clock_gen_chk #(
  parameter int NDET = 4,
  parameter int NGRP = 2,
  parameter int DW   = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 sample_valid,
  input logic [DW-1:0]        sample_data,
  input logic [NGRP-1:0]      grp_evt,
  input logic [NGRP*NDET-1:0] seen,
  input logic [NGRP*NDET-1:0] gmask_q
);

  AST_DATA_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_data) |-> sample_valid); // R7

  AST_VALID_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> $past(|grp_evt)); // R5

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    AST_GROUP_CLEARED: assert property (@(posedge clk) disable iff (rst)
      grp_evt[g] |=> (seen[g*NDET +: NDET] == '0)); // R4

    AST_EMPTY_GROUP_SILENT: assert property (@(posedge clk) disable iff (rst)
      grp_evt[g] |-> (|gmask_q[g*NDET +: NDET])); // R3

    AST_SEEN_IN_MASK: assert property (@(posedge clk) disable iff (rst)
      (seen[g*NDET +: NDET] & ~gmask_q[g*NDET +: NDET]) == '0); // R3
  end

endmodule

bind sample_clock_gen sample_clock_gen_chk #(.NDET(NDET), .NGRP(NGRP), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_data(sample_data),
  .grp_evt(grp_evt), .seen(seen), .gmask_q(gmask_q)
);

// File: tb/sample_clock_gen_tb.sv
`timescale 1ns/1ps
module sample_clock_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sig_in = '0;
  logic [7:0] data_in = '0;
  logic [3:0] qual_in = '0;
  logic [7:0] cfg_det_src;
  logic [3:0] cfg_det_rise, cfg_det_fall;
  logic [1:0] cfg_strb_sel;
  logic [7:0] cfg_grp_mask;
  logic [3:0] cfg_term_grp;
  logic [7:0] cfg_term_care, cfg_term_val;
  logic       sample_valid;
  logic [7:0] sample_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sample_clock_gen u_dut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .data_in(data_in), .qual_in(qual_in),
    .cfg_det_src(cfg_det_src), .cfg_det_rise(cfg_det_rise), .cfg_det_fall(cfg_det_fall),
    .cfg_strb_sel(cfg_strb_sel), .cfg_grp_mask(cfg_grp_mask), .cfg_term_grp(cfg_term_grp),
    .cfg_term_care(cfg_term_care), .cfg_term_val(cfg_term_val),
    .sample_valid(sample_valid), .sample_data(sample_data)
  );

  // {qual_in, sig_in pattern, expected valid}
  localparam logic [8:0] VEC [6] = '{
    {4'b0001, 4'b0001, 1'b1},
    {4'b0011, 4'b0001, 1'b0},
    {4'b0101, 4'b0001, 1'b1},
    {4'b1000, 4'b0001, 1'b0},
    {4'b1000, 4'b0110, 1'b0},
    {4'b1000, 4'b1000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic default_cfg();
    cfg_det_src   = 8'b11_10_01_00;
    cfg_det_rise  = 4'b1011;
    cfg_det_fall  = 4'b0110;
    cfg_strb_sel  = 2'd3;
    cfg_grp_mask  = 8'b0110_0001;
    cfg_term_grp  = 4'b10_01;
    cfg_term_care = 8'b1000_0011;
    cfg_term_val  = 8'b1000_0001;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive(input logic [3:0] v, input logic exp, input string req,
                       input bit chk_d, input logic [7:0] dexp);
    @(negedge clk) sig_in = v;
    @(negedge clk);
    @(negedge clk); chk(req, sample_valid, 1'b0);
    @(negedge clk); chk(req, sample_valid, exp);
    if (chk_d) chk(req, sample_data, dexp);
    @(negedge clk); chk("R7", sample_valid, 1'b0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    default_cfg();
    do_reset();
    chk("R8 reset valid", sample_valid, 1'b0);
    chk("R8 reset data", sample_data, 8'h00);

    // R1 R2 R5: qualifier and group patterns, one reset each
    for (int i = 0; i < 6; i++) begin
      sig_in = '0;
      do_reset();
      qual_in = VEC[i][8:5];
      drive(VEC[i][4:1], VEC[i][0], "R5 vector", 0, 8'h00);
    end

    // R3: group completed by edges in different cycles, wrong polarity ignored
    sig_in = '0;
    do_reset();
    qual_in = 4'b1000;
    drive(4'b0010, 1'b0, "R3 first member", 0, 8'h00);
    drive(4'b0110, 1'b0, "R2 rise not enabled", 0, 8'h00);
    drive(4'b0010, 1'b1, "R3 group complete", 0, 8'h00);

    // R2: falling edge on a detector with both polarities enabled
    drive(4'b0110, 1'b0, "R2 rise ignored", 0, 8'h00);
    drive(4'b0000, 1'b1, "R2 fall counted", 0, 8'h00);

    // R4: history cleared after firing
    drive(4'b0100, 1'b0, "R4 setup", 0, 8'h00);
    drive(4'b0000, 1'b0, "R4 stale member", 0, 8'h00);
    drive(4'b0010, 1'b1, "R4 fresh member", 0, 8'h00);

    // R6: strobe capture, earlier and same-cycle
    qual_in = 4'b0001;
    data_in = 8'hA5;
    drive(4'b1010, 1'b0, "R6 strobe only", 0, 8'h00);
    data_in = 8'h3C;
    drive(4'b1011, 1'b1, "R6 latched word", 1, 8'hA5);
    drive(4'b0010, 1'b0, "R6 release", 1, 8'hA5);
    data_in = 8'h77;
    drive(4'b1011, 1'b1, "R6 same-cycle word", 1, 8'h77);
    chk("R7 data held", sample_data, 8'h77);

    // R8: configuration only at reset
    @(negedge clk) sig_in = '0;
    repeat (3) @(negedge clk);
    cfg_term_care = 8'b1000_0000;
    qual_in = 4'b0011;
    drive(4'b0001, 1'b0, "R8 cfg before reset", 0, 8'h00);
    @(negedge clk) sig_in = '0;
    do_reset();
    drive(4'b0001, 1'b1, "R8 cfg after reset", 0, 8'h00);

    // R8: reset clears remembered edges
    default_cfg();
    sig_in = '0;
    do_reset();
    qual_in = 4'b1000;
    drive(4'b0010, 1'b0, "R8 member seen", 0, 8'h00);
    do_reset();
    drive(4'b0110, 1'b0, "R8 setup", 0, 8'h00);
    drive(4'b0010, 1'b0, "R8 history cleared", 0, 8'h00);

    // R3: empty group mask never fires
    @(negedge clk) sig_in = '0;
    cfg_grp_mask = 8'b0110_0000;
    do_reset();
    qual_in = 4'b0001;
    drive(4'b0001, 1'b0, "R3 empty group", 0, 8'h00);

    // R1: detector 0 moved to line 2
    @(negedge clk) sig_in = '0;
    cfg_grp_mask = 8'b0110_0001;
    cfg_det_src  = 8'b11_10_01_10;
    do_reset();
    drive(4'b0001, 1'b0, "R1 old line ignored", 0, 8'h00);
    drive(4'b0101, 1'b1, "R1 new line", 0, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule